// File: doc/BRIEF.md
# Page Write Collector with Load Timer

This block sits behind an asynchronous parallel memory bus with active-low chip-select, write-strobe and read-enable lines. It samples that bus with a system clock, turns each qualified low pulse into a byte write, and gathers these writes in a page-sized staging buffer. A row of valid bits records which byte offsets were loaded. A retriggerable idle timer runs after each write. When the timer runs out, the block raises a commit request toward the programming engine.

The request carries the page number, the valid mask and a read port into the staged bytes. The engine programs only the offsets whose mask bits are set, then pulses a done input. Writes that arrive while a commit is pending are dropped. A programmable minimum pulse length rejects short glitches on either enable line. The address is taken when the write window opens, which is the later of the two falling edges. The data is taken when the window closes, which is the earlier of the two rising edges.

Top module: `page_write_collector`

## Requirements
- R1: After reset, `commit_req` is 0, `commit_mask` is all zero and `commit_page` is 0.
- R2: A byte write is accepted only while `bus_cs_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. If `bus_oe_n` is held low, no byte is accepted.
- R3: The address is the value present in the first sampled cycle of the write window. The data is the value present in the last sampled cycle before `bus_cs_n` or `bus_we_n` rises.
- R4: Address bits [12:5] give the page, and the page of the last accepted write of a load is reported. Bits [4:0] give the byte offset, offsets may arrive in any order, and bit k of `commit_mask` marks offset k.
- R5: The last write of a load ends on the clock-domain side with a rise of the controlling enable. `commit_req` rises exactly LOAD_WIN+4 clock cycles after that rise is driven, counted from the falling clock edge on which it is driven.
- R6: During a commit, `commit_mask` holds exactly the loaded offsets. `rd_data` returns the last byte written to offset `rd_ofs`, one clock after `rd_ofs` is presented.
- R7: A write window shorter than MIN_PULSE sampled cycles is discarded. A window of exactly MIN_PULSE cycles is accepted.
- R8: If one offset is written twice in a load, the later data is staged.
- R9: While `commit_req` is 1, bus writes change neither the mask nor the staged data. One cycle after `commit_done`, `commit_req` is 0 and the mask is clear.
- R10: A new write window that opens before the timer expires cancels the pending expiry. The next expiry is timed from the end of the new write.
- R11: Writes in which the chip-select is the last line to fall and the first to rise behave the same as writes controlled by the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus chip-select, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_oe_n | input | 1 | Bus read enable, active low; low inhibits writes |
| bus_addr | input | 13 | Bus byte address |
| bus_din | input | 8 | Bus write data |
| commit_done | input | 1 | Programming engine finished the commit |
| rd_ofs | input | 5 | Staged byte offset to read |
| commit_req | output | 1 | Commit pending |
| commit_page | output | 8 | Page number of the pending load |
| commit_mask | output | 32 | One bit per loaded byte offset |
| rd_data | output | 8 | Staged byte at `rd_ofs`, one cycle later |

## Verification
The bench builds the block with LOAD_WIN=16 and MIN_PULSE=3. The short window makes timer expiry and restart cheap to reach, so exact commit latency can be checked many times in one run. With a three-cycle minimum, the bench can drive a two-cycle pulse that must be dropped right next to a three-cycle pulse that must be kept. A table of out-of-order writes, with a repeated offset and a page change on the final entry, covers mask building, later-data-wins and last-page reporting in a single load.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int OFS_W  = 5;
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int NBYTES = 1 << OFS_W;

  typedef struct packed {
    logic              cs_n;
    logic              we_n;
    logic              oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_smp_t;

  localparam int SMP_W = $bits(bus_smp_t);
endpackage

// File: rtl/pgc_sampler.sv
module pgc_sampler #(
  parameter int W      = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pgc_write_qual.sv
module pgc_write_qual
  import pgc_pkg::*;
#(
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_smp_t          smp,
  output logic              open_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int LEN_W = $clog2(MIN_PULSE + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MIN_PULSE);

  logic             act, act_q;
  logic [LEN_W-1:0] len;
  logic             closed_ok;

  assign act = !smp.cs_n && !smp.we_n && smp.oe_n;
  // window closed by an enable rising, with output-enable still high
  assign closed_ok = act_q && !act && (smp.cs_n || smp.we_n) && smp.oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      len      <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      open_stb <= 1'b0;
      wr_stb   <= 1'b0;
    end else begin
      act_q    <= act;
      open_stb <= act && !act_q;
      wr_stb   <= closed_ok && (len >= LEN_MAX);
      if (act && !act_q) begin
        wr_addr <= smp.addr;
        len     <= LEN_W'(1);
      end else if (act && len != LEN_MAX) begin
        len <= len + 1'b1;
      end
      if (act) wr_data <= smp.data;
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb) else $error("write strobe longer than one cycle"); // R2
  AST_OPEN_NOT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    open_stb |-> !wr_stb) else $error("window opened and closed together"); // R3
endmodule

// File: rtl/pgc_load_timer.sv
module pgc_load_timer #(
  parameter int LOAD_WIN = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic stop,
  output logic expire
);
  localparam int CNT_W = (LOAD_WIN > 1) ? $clog2(LOAD_WIN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_WIN - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign expire = armed && (cnt == LAST) && !arm && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (stop) begin
      armed <= 1'b0;
    end else if (armed) begin
      if (cnt == LAST) armed <= 1'b0;
      else             cnt   <= cnt + 1'b1;
    end
  end

  AST_EXPIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    expire |=> !armed) else $error("timer still armed after expiry"); // R5
  AST_STOP_CANCELS: assert property (@(posedge clk) disable iff (rst)
    (stop && !arm) |=> !expire) else $error("expiry after stop"); // R10
endmodule

// File: rtl/pgc_page_buf.sv
module pgc_page_buf
  import pgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [PAGE_W-1:0] page,
  output logic [NBYTES-1:0] mask,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [NBYTES];
  logic [OFS_W-1:0]  wofs;

  assign wofs = wr_addr[OFS_W-1:0];

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wofs] <= wr_data;
    rd_data <= mem[rd_ofs];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      mask <= '0;
    end else if (clr) begin
      mask <= '0;
    end else if (wr_en) begin
      page       <= wr_addr[ADDR_W-1:OFS_W];
      mask[wofs] <= 1'b1;
    end
  end

  AST_MASK_GROWS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> mask[$past(wofs)]) else $error("offset not marked"); // R4
endmodule

// File: rtl/page_write_collector.sv
module page_write_collector
  import pgc_pkg::*;
#(
  parameter int LOAD_WIN  = 5000,
  parameter int MIN_PULSE = 2,
  parameter int SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              commit_done,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic              commit_req,
  output logic [PAGE_W-1:0] commit_page,
  output logic [NBYTES-1:0] commit_mask,
  output logic [DATA_W-1:0] rd_data
);
  localparam bus_smp_t SMP_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                    addr: '0, data: '0};

  bus_smp_t          raw, smp;
  logic              open_stb, wr_stb, expire, busy, take;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign raw = '{cs_n: bus_cs_n, we_n: bus_we_n, oe_n: bus_oe_n,
                 addr: bus_addr, data: bus_din};

  pgc_sampler #(.W(SMP_W), .STAGES(SYNC_N), .RST_VAL(SMP_IDLE)) u_smp (
    .clk(clk), .rst(rst), .d(raw), .q(smp)
  );

  pgc_write_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst(rst), .smp(smp), .open_stb(open_stb),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign take = wr_stb && !busy;

  pgc_load_timer #(.LOAD_WIN(LOAD_WIN)) u_tmr (
    .clk(clk), .rst(rst), .arm(take), .stop(open_stb), .expire(expire)
  );

  pgc_page_buf u_buf (
    .clk(clk), .rst(rst), .wr_en(take), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr(busy && commit_done), .rd_ofs(rd_ofs), .page(commit_page),
    .mask(commit_mask), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)                      busy <= 1'b0;
    else if (busy && commit_done) busy <= 1'b0;
    else if (expire)              busy <= 1'b1;
  end

  assign commit_req = busy;

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit_done) |=> busy) else $error("request dropped early"); // R9
  AST_REQ_HAS_BYTES: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (commit_mask != '0)) else $error("empty commit"); // R6
  AST_FROZEN_IN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (busy && !commit_done) |=> ($stable(commit_mask) && $stable(commit_page)))
    else $error("load changed during commit"); // R9
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (busy && commit_done) |=> (!busy && commit_mask == '0))
    else $error("commit not released"); // R9
endmodule

// File: tb/page_write_collector_test.sv
module page_write_collector_test;
  localparam int WIN = 16;
  localparam int MINP = 3;
  localparam int LAT = WIN + 4;

  logic clk = 0, rst = 1;
  logic cs_n = 1, we_n = 1, oe_n = 1, done_in = 0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic [4:0]  rd_ofs = '0;
  logic        req;
  logic [7:0]  page, rdat;
  logic [31:0] mask;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  page_write_collector #(.LOAD_WIN(WIN), .MIN_PULSE(MINP)) uut (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_addr(addr), .bus_din(din), .commit_done(done_in), .rd_ofs(rd_ofs),
    .commit_req(req), .commit_page(page), .commit_mask(mask), .rd_data(rdat)
  );

  // table: {address, data}
  localparam logic [20:0] VEC [6] = '{
    {8'h4B, 5'd7,  8'h11}, {8'h4B, 5'd0,  8'h22}, {8'h4B, 5'd31, 8'h33},
    {8'h4B, 5'd12, 8'h44}, {8'h4B, 5'd7,  8'h55}, {8'h4C, 5'd19, 8'h66}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d,
                           input int len, input bit cs_ctl);
    @(negedge clk); addr = a; din = d;
    if (cs_ctl) we_n = 0; else cs_n = 0;
    @(negedge clk);
    if (cs_ctl) cs_n = 0; else we_n = 0;
    repeat (len) @(negedge clk);
    if (cs_ctl) cs_n = 1; else we_n = 1;
    @(negedge clk); cs_n = 1; we_n = 1;
  endtask

  task automatic wait_commit(output int n);
    n = 1;
    while (!req && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic read_ofs(input logic [4:0] o, output logic [7:0] v);
    @(negedge clk); rd_ofs = o;
    @(negedge clk); v = rdat;
  endtask

  task automatic finish_commit;
    @(negedge clk); done_in = 1;
    @(negedge clk); done_in = 0;
  endtask

  initial begin
    int n;
    logic [7:0] v;
    logic [7:0] expd [32];
    logic [31:0] expm;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req == 0 && mask == 0 && page == 0, "R1 reset state", {req, mask[7:0]}, 0);

    // table-driven load, alternating write-strobe and chip-select control
    expm = '0;
    for (int i = 0; i < 6; i++) begin
      bus_write(VEC[i][20:8], VEC[i][7:0], 3, i[0]);
      expm[VEC[i][12:8]] = 1'b1;
      expd[VEC[i][12:8]] = VEC[i][7:0];
      if (i < 5) repeat (2) @(negedge clk);
    end
    check(req == 0, "R5 no request right after last write", req, 0);
    wait_commit(n);
    check(n == LAT, "R5 commit latency", n, LAT);
    check(page == 8'h4C, "R4 page from last write", page, 8'h4C);
    check(mask == expm, "R4 R6 mask of loaded offsets", mask, expm);
    for (int i = 0; i < 32; i++) begin
      if (expm[i]) begin
        read_ofs(5'(i), v);
        check(v == expd[i], "R6 R8 R11 staged byte", v, expd[i]);
      end
    end

    // writes during a commit are dropped
    bus_write({8'h4B, 5'd0}, 8'hEE, 3, 0);
    bus_write({8'h70, 5'd2}, 8'hEF, 3, 0);
    repeat (6) @(negedge clk);
    check(mask == expm && page == 8'h4C, "R9 mask frozen during commit", mask, expm);
    read_ofs(5'd0, v);
    check(v == 8'h22, "R9 data frozen during commit", v, 8'h22);
    finish_commit;
    check(req == 0 && mask == 0, "R9 done releases request", {req, mask[7:0]}, 0);

    // minimum pulse
    bus_write({8'h05, 5'd4}, 8'hA1, MINP - 1, 0);
    repeat (WIN + 10) @(negedge clk);
    check(req == 0 && mask == 0, "R7 short pulse dropped", mask, 0);
    bus_write({8'h05, 5'd4}, 8'hA2, MINP, 1);
    wait_commit(n);
    check(n == LAT && mask == 32'h10, "R7 R11 minimum pulse accepted", mask, 32'h10);
    finish_commit;

    // output-enable low inhibits
    @(negedge clk); oe_n = 0; addr = {8'h06, 5'd1}; cs_n = 0;
    @(negedge clk); we_n = 0;
    repeat (5) @(negedge clk);
    we_n = 1; cs_n = 1;
    @(negedge clk); oe_n = 1;
    repeat (WIN + 10) @(negedge clk);
    check(req == 0 && mask == 0, "R2 inhibited by output enable", mask, 0);

    // address at window open, data at window close
    @(negedge clk); addr = {8'h11, 5'd3}; din = 8'hC1; cs_n = 0;
    @(negedge clk); we_n = 0;
    @(negedge clk); addr = {8'h22, 5'd9}; din = 8'hC2;
    repeat (3) @(negedge clk);
    we_n = 1;
    @(negedge clk); cs_n = 1;
    wait_commit(n);
    check(mask == 32'h8 && page == 8'h11, "R3 address from window open", mask, 32'h8);
    read_ofs(5'd3, v);
    check(v == 8'hC2, "R3 data from window close", v, 8'hC2);
    finish_commit;

    // restart of the timer by a new write
    bus_write({8'h30, 5'd1}, 8'hB1, 3, 0);
    repeat (6) @(negedge clk);
    check(req == 0, "R10 no commit inside window", req, 0);
    bus_write({8'h30, 5'd2}, 8'hB2, 3, 0);
    wait_commit(n);
    check(n == LAT, "R10 latency timed from newest write", n, LAT);
    check(mask == 32'h6, "R10 both bytes in one load", mask, 32'h6);
    finish_commit;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule